// File: doc/BRIEF.md
# Line adapter timer unit

This block holds the three timers of a synchronous serial line adapter. The long timer, nominally 3 s, guards two things: the listening period in receive mode, and the wait for clear-to-send in transmit or synchronize mode. The sync timer, nominally 1.25 s, repeats in synchronize mode to tell the host that an idle or sync burst is due. The program timer, nominally 0.35 s, is a host interval timer that runs only with the binary-synchronous protocol.

All three timers count one shared prescaled tick. Each timer's terminal count is a parameter, so a bench can shorten the periods. The host drives single-cycle command strobes:
- toggle flips an inhibit trigger;
- restart reloads whichever timers are running;
- clear drops the shared timeout status;
- reset command clears the timers and the trigger.

The inhibit trigger is a two-state machine. In state TRIG_FREE the long and sync timers run when their mode allows. In state TRIG_PROG those two timers are frozen and the program timer runs.

The machine has three transitions. TRIG_FREE goes to TRIG_PROG on toggle. TRIG_PROG goes back to TRIG_FREE on toggle or on program timer expiry. Either state goes to TRIG_FREE on the reset command.

Any expiry sets a sticky timeout status and gives a one-cycle interrupt request. A source flag shows which timer expired.

Top module: `sync_timer_unit`

## Requirements
- R1: After rst_n is released, `tmo_status`, `irq_req`, `inhibit` and `src_flags` are all 0.
- R2: With mode = 1 (receive), the long timer starts from zero when the mode is entered. After LONG_TICKS ticks with no restart it expires, and `src_flags` bit 0 is set for one cycle.
- R3: With mode = 2 (transmit) or 3 (synchronize), the long timer counts only while `cts` is 0. A high `cts` clears it, so no long-timer timeout can occur.
- R4: With mode = 3, the sync timer expires every SYNC_TICKS ticks, setting `src_flags` bit 1. In any other mode it is cleared.
- R5: A `cmd_toggle` strobe flips the trigger, which is seen on `inhibit` in the next cycle. While `inhibit` is 1, the long and sync timers keep their count and cannot expire.
- R6: With `proto_bsc` = 1 and `inhibit` = 1, the program timer expires after PROG_TICKS ticks. It then sets `src_flags` bit 2 and returns `inhibit` to 0 in the same cycle.
- R7: With `proto_bsc` = 0 (STR), the program timer stays cleared. `inhibit` then stays 1 until the next toggle.
- R8: A `cmd_restart` strobe reloads each running timer to zero. It does not change a frozen timer.
- R9: Any expiry sets `tmo_status` and raises `irq_req` for exactly that one cycle. `tmo_status` stays 1 until `cmd_clear`; an expiry in the same cycle as `cmd_clear` wins.
- R10: A `cmd_reset` strobe clears all timers, the prescaler and the trigger, so `inhibit` is 0 in the next cycle.
- R11: Any change of mode reloads all timers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Line mode: 0 off, 1 receive, 2 transmit, 3 synchronize |
| proto_bsc | input | 1 | 1 = binary synchronous, 0 = STR |
| cts | input | 1 | Clear-to-send from the data set |
| cmd_toggle | input | 1 | Strobe: flip the inhibit trigger |
| cmd_restart | input | 1 | Strobe: reload running timers |
| cmd_clear | input | 1 | Strobe: clear timeout status |
| cmd_reset | input | 1 | Strobe: clear timers and trigger |
| tmo_status | output | 1 | Sticky timeout status |
| irq_req | output | 1 | One-cycle interrupt request on expiry |
| src_flags | output | 3 | Expiry source: bit 0 long, bit 1 sync, bit 2 program |
| inhibit | output | 1 | Trigger state: 1 = long and sync frozen, program timer armed |

## Verification
Directed runs come first, one per effect:
- An unattended receive period, which must reach a timeout.
- Periodic restarts, which must keep the long timer from expiring.
- A freeze with a restart inside it: the timer must expire early after release, which separates "held" from "reloaded".
- A mode switch at three quarters of a period, which must push the timeout back by a full period.
- A toggle under each protocol, which shows whether the program timer self-releases or stays idle.

Random phases then mix modes, `cts` flips and every strobe, including strobes that coincide with expiries. The outputs are compared every cycle against a bench model built from the requirements, which exposes off-by-one counts and priority errors.

// File: rtl/sync_tmr_pkg.sv
package sync_tmr_pkg;

    typedef enum logic [1:0] {
        MD_OFF  = 2'd0,
        MD_RX   = 2'd1,
        MD_TX   = 2'd2,
        MD_SYNC = 2'd3
    } line_mode_t;

    typedef enum logic {
        TRIG_FREE = 1'b0,
        TRIG_PROG = 1'b1
    } trig_state_t;

    localparam int NUM_TMR  = 3;
    localparam int TMR_LONG = 0;
    localparam int TMR_SYNC = 1;
    localparam int TMR_PROG = 2;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt;

    assign tick = (pcnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (sclr || tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int LIMIT = 300,
    parameter int CW    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic active,
    input  logic hold,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    localparam logic [CW-1:0] TERM = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;
    logic          running;

    // running: mode allows counting and not frozen by the trigger
    assign running = active && !hold && !clr;
    assign expire  = running && !restart && tick && (cnt == TERM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || !active)
            cnt <= '0;
        else if (hold)
            cnt <= cnt;
        else if (restart)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == TERM) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import sync_tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_reset,
    input  logic               cmd_toggle,
    input  logic               cmd_clear,
    input  logic [NUM_TMR-1:0] expire,
    output logic               inhibit,
    output logic               tmo_status,
    output logic               irq_req,
    output logic [NUM_TMR-1:0] src_flags
);
    trig_state_t state, state_nx;
    logic        any_exp;

    assign any_exp = |expire;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= TRIG_FREE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (cmd_reset) begin
            state_nx = TRIG_FREE;
        end else begin
            unique case (state)
                TRIG_FREE: if (cmd_toggle) state_nx = TRIG_PROG;
                TRIG_PROG: if (expire[TMR_PROG] || cmd_toggle) state_nx = TRIG_FREE;
                default:   state_nx = TRIG_FREE;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            TRIG_FREE: inhibit = 1'b0;
            TRIG_PROG: inhibit = 1'b1;
            default:   inhibit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_status <= 1'b0;
            irq_req    <= 1'b0;
            src_flags  <= '0;
        end else begin
            irq_req   <= any_exp;
            src_flags <= expire;
            if (any_exp)
                tmo_status <= 1'b1;
            else if (cmd_clear)
                tmo_status <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_timer_unit.sv
module sync_timer_unit
    import sync_tmr_pkg::*;
#(
    parameter int TICK_DIV   = 1000000,
    parameter int LONG_TICKS = 300,
    parameter int SYNC_TICKS = 125,
    parameter int PROG_TICKS = 35
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       proto_bsc,
    input  logic       cts,
    input  logic       cmd_toggle,
    input  logic       cmd_restart,
    input  logic       cmd_clear,
    input  logic       cmd_reset,
    output logic       tmo_status,
    output logic       irq_req,
    output logic [2:0] src_flags,
    output logic       inhibit
);
    localparam int LIMS [NUM_TMR] = '{LONG_TICKS, SYNC_TICKS, PROG_TICKS};
    localparam int MAXL = (LONG_TICKS > SYNC_TICKS)
                        ? ((LONG_TICKS > PROG_TICKS) ? LONG_TICKS : PROG_TICKS)
                        : ((SYNC_TICKS > PROG_TICKS) ? SYNC_TICKS : PROG_TICKS);
    localparam int CW = (MAXL > 1) ? $clog2(MAXL) : 1;

    line_mode_t         cur_mode, prev_mode;
    logic               tick, mode_chg, clr_all;
    logic [NUM_TMR-1:0] act, hld, expire;

    assign cur_mode = line_mode_t'(mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_mode <= MD_OFF;
        else
            prev_mode <= cur_mode;
    end

    assign mode_chg = (cur_mode != prev_mode);
    assign clr_all  = cmd_reset || mode_chg;

    tmr_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .sclr (cmd_reset),
        .tick (tick)
    );

    always_comb begin
        act[TMR_LONG] = (cur_mode == MD_RX)
                     || (((cur_mode == MD_TX) || (cur_mode == MD_SYNC)) && !cts);
        act[TMR_SYNC] = (cur_mode == MD_SYNC);
        act[TMR_PROG] = inhibit && proto_bsc;
        hld[TMR_LONG] = inhibit;
        hld[TMR_SYNC] = inhibit;
        hld[TMR_PROG] = 1'b0;
    end

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        tmr_count #(.LIMIT(LIMS[g]), .CW(CW)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_all),
            .active (act[g]),
            .hold   (hld[g]),
            .restart(cmd_restart),
            .tick   (tick),
            .expire (expire[g])
        );
    end

    tmr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_reset (cmd_reset),
        .cmd_toggle(cmd_toggle),
        .cmd_clear (cmd_clear),
        .expire    (expire),
        .inhibit   (inhibit),
        .tmo_status(tmo_status),
        .irq_req   (irq_req),
        .src_flags (src_flags)
    );
endmodule

// File: rtl/sync_tmr_chk.sv
module sync_tmr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       proto_bsc,
    input logic       cmd_clear,
    input logic       tmo_status,
    input logic       irq_req,
    input logic [2:0] src_flags,
    input logic       inhibit
);
    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_status && !cmd_clear |=> tmo_status);

    a_r9_irq_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> tmo_status);

    a_r9_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (src_flags != 3'b000));

    a_r9_source_has_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (src_flags != 3'b000) |-> irq_req);

    a_r6_prog_releases: assert property (@(posedge clk) disable iff (!rst_n)
        src_flags[2] |-> !inhibit);

    a_r7_str_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
        src_flags[2] |-> $past(proto_bsc));

    a_r5_long_held: assert property (@(posedge clk) disable iff (!rst_n)
        src_flags[0] |-> !$past(inhibit));

    a_r5_sync_held: assert property (@(posedge clk) disable iff (!rst_n)
        src_flags[1] |-> !$past(inhibit));
endmodule

bind sync_timer_unit sync_tmr_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .proto_bsc (proto_bsc),
    .cmd_clear (cmd_clear),
    .tmo_status(tmo_status),
    .irq_req   (irq_req),
    .src_flags (src_flags),
    .inhibit   (inhibit)
);

// File: tb/test_sync_timer_unit.sv
`timescale 1ns/1ps
module test_sync_timer_unit;
    localparam int DIV = 4;
    localparam int LL  = 30;
    localparam int LS  = 12;
    localparam int LP  = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       proto_bsc = 1'b1;
    logic       cts = 1'b0;
    logic       cmd_toggle = 1'b0, cmd_restart = 1'b0, cmd_clear = 1'b0, cmd_reset = 1'b0;
    logic       tmo_status, irq_req, inhibit;
    logic [2:0] src_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    sync_timer_unit #(.TICK_DIV(DIV), .LONG_TICKS(LL), .SYNC_TICKS(LS), .PROG_TICKS(LP)) i_sync_timer_unit (
        .clk(clk), .rst_n(rst_n), .mode(mode), .proto_bsc(proto_bsc), .cts(cts),
        .cmd_toggle(cmd_toggle), .cmd_restart(cmd_restart), .cmd_clear(cmd_clear),
        .cmd_reset(cmd_reset), .tmo_status(tmo_status), .irq_req(irq_req),
        .src_flags(src_flags), .inhibit(inhibit)
    );

    // reference model, written from the requirements
    int unsigned m_p;
    int unsigned m_c [3];
    bit          m_trig, m_stat, m_irq;
    bit [2:0]    m_src;
    bit [1:0]    m_prev;

    function automatic int unsigned lim(int i);
        return (i == 0) ? LL : (i == 1) ? LS : LP;
    endfunction

    task automatic model_step();
        bit tick, clr;
        bit [2:0] act, inh, ex;
        tick = (m_p == DIV - 1);
        clr  = cmd_reset || (mode != m_prev);
        act[0] = (mode == 2'd1) || (((mode == 2'd2) || (mode == 2'd3)) && !cts);
        act[1] = (mode == 2'd3);
        act[2] = m_trig && proto_bsc;
        inh = {1'b0, m_trig, m_trig};
        for (int i = 0; i < 3; i++) begin
            ex[i] = !clr && act[i] && !inh[i] && !cmd_restart && tick && (m_c[i] == lim(i) - 1);
            if (clr || !act[i])  m_c[i] = 0;
            else if (inh[i])     m_c[i] = m_c[i];
            else if (cmd_restart) m_c[i] = 0;
            else if (tick)       m_c[i] = (m_c[i] == lim(i) - 1) ? 0 : m_c[i] + 1;
        end
        if (cmd_reset)       m_trig = 0;
        else if (ex[2])      m_trig = 0;
        else if (cmd_toggle) m_trig = !m_trig;
        if (|ex)             m_stat = 1;
        else if (cmd_clear)  m_stat = 0;
        m_irq  = |ex;
        m_src  = ex;
        m_p    = (cmd_reset || tick) ? 0 : m_p + 1;
        m_prev = mode;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_p = 0; m_c[0] = 0; m_c[1] = 0; m_c[2] = 0;
            m_trig = 0; m_stat = 0; m_irq = 0; m_src = 0; m_prev = 0;
        end else begin
            model_step();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk("R9 tmo_status", tmo_status, m_stat);
            chk("R9 irq_req", irq_req, m_irq);
            chk("R2 R3 long expiry", src_flags[0], m_src[0]);
            chk("R4 sync expiry", src_flags[1], m_src[1]);
            chk("R6 R7 program expiry", src_flags[2], m_src[2]);
            chk("R5 R10 inhibit", inhibit, m_trig);
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int which);
        case (which)
            0: cmd_toggle  = 1'b1;
            1: cmd_restart = 1'b1;
            2: cmd_clear   = 1'b1;
            default: cmd_reset = 1'b1;
        endcase
        @(negedge clk);
        cmd_toggle = 1'b0; cmd_restart = 1'b0; cmd_clear = 1'b0; cmd_reset = 1'b0;
    endtask

    task automatic fresh(input logic [1:0] md);
        mode = 2'd0;
        wait_cyc(2);
        strobe(2);
        mode = md;
    endtask

    initial begin
        void'($urandom(1130));
        wait_cyc(3);
        chk("R1 reset status", tmo_status, 0);
        chk("R1 reset inhibit", inhibit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset src", src_flags, 0);
        chk("R1 after reset irq", irq_req, 0);

        // R2: unattended receive period
        mode = 2'd1; cts = 1'b0;
        wait_cyc(LL * DIV - 10);
        chk("R2 no timeout before period", tmo_status, 0);
        wait_cyc(20);
        chk("R2 receive timeout", tmo_status, 1);

        // R9: clear
        strobe(2);
        chk("R9 clear strobe", tmo_status, 0);

        // R8: restarts keep long timer alive
        for (int k = 0; k < 5; k++) begin
            wait_cyc(60);
            strobe(1);
        end
        chk("R8 restart keeps timer alive", tmo_status, 0);

        // R8/R5: restart has no effect while frozen
        proto_bsc = 1'b0;
        fresh(2'd1);
        wait_cyc(80);
        strobe(0);
        chk("R5 toggle sets inhibit", inhibit, 1);
        strobe(1);
        wait_cyc(50);
        chk("R5 frozen timer does not expire", tmo_status, 0);
        strobe(0);
        chk("R5 toggle clears inhibit", inhibit, 0);
        wait_cyc(60);
        chk("R8 frozen timer not reloaded", tmo_status, 1);

        // R11: mode change reloads
        fresh(2'd1);
        wait_cyc(100);
        mode = 2'd2; cts = 1'b0;
        wait_cyc(100);
        chk("R11 mode change reloads", tmo_status, 0);
        wait_cyc(40);
        chk("R3 transmit cts timeout", tmo_status, 1);

        // R3: cts high prevents timeout
        cts = 1'b1;
        fresh(2'd2);
        wait_cyc(200);
        chk("R3 cts high no timeout", tmo_status, 0);

        // R4: sync timer
        fresh(2'd3);
        wait_cyc(LS * DIV + 6);
        chk("R4 sync due", tmo_status, 1);

        // R6: program timer self-release in BSC
        proto_bsc = 1'b1;
        fresh(2'd0);
        strobe(0);
        chk("R6 armed", inhibit, 1);
        wait_cyc(LP * DIV + 6);
        chk("R6 self release", inhibit, 0);
        chk("R6 program timeout", tmo_status, 1);

        // R7: STR keeps the program timer idle
        proto_bsc = 1'b0;
        fresh(2'd0);
        strobe(0);
        wait_cyc(100);
        chk("R7 inhibit stays", inhibit, 1);
        chk("R7 no program timeout", tmo_status, 0);

        // R10: reset command
        strobe(3);
        chk("R10 reset command clears trigger", inhibit, 0);

        // random phases
        for (int ph = 0; ph < 12; ph++) begin
            mode      = 2'($urandom_range(0, 3));
            proto_bsc = 1'($urandom_range(0, 1));
            cts       = 1'($urandom_range(0, 1));
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                cmd_restart = ($urandom_range(0, 39) == 0);
                cmd_toggle  = ($urandom_range(0, 79) == 0);
                cmd_clear   = ($urandom_range(0, 29) == 0);
                cmd_reset   = ($urandom_range(0, 299) == 0);
                if ($urandom_range(0, 49) == 0) cts = ~cts;
                if ($urandom_range(0, 149) == 0) mode = 2'($urandom_range(0, 3));
            end
            cmd_restart = 0; cmd_toggle = 0; cmd_clear = 0; cmd_reset = 0;
        end
        wait_cyc(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule